// File: doc/BRIEF.md
# Vectored Interrupt Controller Unit

This unit gathers eight event conditions from a serial communications peripheral (receiver and transmitter channels, a counter/timer, input change detectors) into a status register. A mask register selects which of those conditions may pull a single active-low interrupt request line. The logic that raises and clears the conditions sits outside the unit. The unit sees them as plain level inputs.

A processor reaches the unit over a byte-wide register bus. The bus has read and write strobes, a two-bit address, write data, read data with an output-enable, and an active-low data-acknowledge. When the processor starts an interrupt-acknowledge cycle by pulling the acknowledge strobe low while the request line is active, the unit places a programmable vector byte on the read data bus and answers with data-acknowledge. If no enabled interrupt is pending, the unit stays silent, so another device may answer.

The bus is a plain strobe-and-acknowledge interface, not a stream. Every accepted strobe cycle is answered with data-acknowledge on the following clock. There is no back-pressure: the unit never stalls a request.

Top module: `irqv_top`

## Requirements
- R1: After reset, `irq_n` and `dack_n` are high, `cpu_rdata_oe` is low, the mask register reads 0x00 and the vector register reads 0x0F.
- R2: A read at address 0 returns the event levels captured on the previous clock edge, for masked and unmasked events alike.
- R3: Address 1 holds the 8-bit mask register and address 2 the 8-bit vector register, both readable and writable. A write to address 0 or address 3 changes no register. Address 3 reads 0x00.
- R4: `irq_n` goes low one clock after the status register holds an event whose mask bit is 1. This is two clocks after the event input rises. `irq_n` returns high one clock after the last such status bit clears.
- R5: An event whose mask bit is 0 never pulls `irq_n` low.
- R6: If `iack_n` is low on a clock edge while `irq_n` is low, then on the next cycle `cpu_rdata` equals the vector register, `cpu_rdata_oe` is high and `dack_n` is low.
- R7: If `iack_n` is low while `irq_n` is high and no strobe is active, `dack_n` stays high and `cpu_rdata_oe` stays low.
- R8: A read or write strobe sampled on a clock edge makes `dack_n` low for the next cycle. A read also drives `cpu_rdata_oe` high with the register value. With no strobe and no answered acknowledge, `dack_n` is high.
- R9: An answered interrupt-acknowledge takes precedence over a read or write strobe in the same cycle. The vector is returned and the write is dropped.
- R10: Reading the status register does not clear any status bit. Bits clear only when their event inputs fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | Event condition levels from the peripheral |
| cpu_rd | input | 1 | Read strobe, active high |
| cpu_wr | input | 1 | Write strobe, active high |
| cpu_addr | input | 2 | Register address: 0 status, 1 mask, 2 vector |
| cpu_wdata | input | 8 | Write data |
| iack_n | input | 1 | Interrupt-acknowledge strobe, active low |
| cpu_rdata | output | 8 | Read data or vector |
| cpu_rdata_oe | output | 1 | High while `cpu_rdata` is being driven |
| dack_n | output | 1 | Data-acknowledge, active low |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bench counts register stages from each stimulus, so a corrupt mask register shows up as an `irq_n` value that is wrong two clocks after an event is raised. A read of address 1 on the next access exposes the same fault. A corrupt vector register shows up at `cpu_rdata` in the cycle right after an answered acknowledge. A stuck status bit shows up on the next status read and on the release timing of `irq_n`. A faulty responder shows up one clock after the strobe, either as a wrong `dack_n` level or as a missing or stray `cpu_rdata_oe`.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_STATUS = 2'd0;
  localparam logic [ADDR_W-1:0] A_MASK   = 2'd1;
  localparam logic [ADDR_W-1:0] A_VECTOR = 2'd2;

  typedef enum logic [1:0] {
    RSP_NONE,
    RSP_VECTOR,
    RSP_READ,
    RSP_WRITE
  } rsp_e;
endpackage

// File: rtl/irqv_status.sv
module irqv_status #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] status_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= evt_i[i];
    end
    assign status_o[i] = q;
  end
endmodule

// File: rtl/irqv_regs.sv
module irqv_regs #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 2,
  parameter logic [DW-1:0] VEC_RST = 8'h0F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] vector_o
);
  import irqv_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o   <= '0;
      vector_o <= VEC_RST;
    end else if (wr_en) begin
      if (addr == A_MASK)   mask_o   <= wdata;
      if (addr == A_VECTOR) vector_o <= wdata;
    end
  end
endmodule

// File: rtl/irqv_req.sv
module irqv_req #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] status,
  input  logic [N-1:0] mask,
  output logic         irq_n
);
  logic any_enabled;
  assign any_enabled = |(status & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n <= 1'b1;
    else        irq_n <= ~any_enabled;
  end
endmodule

// File: rtl/irqv_bus.sv
module irqv_bus #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic          iack_n,
  input  logic          irq_n,
  input  logic [DW-1:0] status,
  input  logic [DW-1:0] mask,
  input  logic [DW-1:0] vector,
  output logic          wr_accept,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe,
  output logic          dack_n
);
  import irqv_pkg::*;

  rsp_e          kind;
  logic [DW-1:0] rmux;

  always_comb begin
    if (!iack_n && !irq_n) kind = RSP_VECTOR;
    else if (rd)           kind = RSP_READ;
    else if (wr)           kind = RSP_WRITE;
    else                   kind = RSP_NONE;
  end

  always_comb begin
    case (addr)
      A_STATUS: rmux = status;
      A_MASK:   rmux = mask;
      A_VECTOR: rmux = vector;
      default:  rmux = '0;
    endcase
  end

  assign wr_accept = (kind == RSP_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      rdata_oe <= 1'b0;
      dack_n   <= 1'b1;
    end else begin
      rdata    <= '0;
      rdata_oe <= 1'b0;
      dack_n   <= 1'b1;
      case (kind)
        RSP_VECTOR: begin rdata <= vector; rdata_oe <= 1'b1; dack_n <= 1'b0; end
        RSP_READ:   begin rdata <= rmux;   rdata_oe <= 1'b1; dack_n <= 1'b0; end
        RSP_WRITE:  dack_n <= 1'b0;
        default:    ;
      endcase
    end
  end

  AST_IACK_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (!iack_n && !irq_n) |=> (!dack_n && rdata_oe && rdata == $past(vector))); // R6
  AST_IACK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!iack_n && irq_n && !rd && !wr) |=> (dack_n && !rdata_oe)); // R7
  AST_OE_HAS_DACK: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> !dack_n); // R8
  AST_NO_STRAY_DACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd && !wr && iack_n) |=> dack_n); // R8
  AST_IACK_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!iack_n && !irq_n) |-> !wr_accept); // R9
endmodule

// File: rtl/irqv_top.sv
module irqv_top #(
  parameter int unsigned DW = irqv_pkg::DATA_W,
  parameter int unsigned AW = irqv_pkg::ADDR_W,
  parameter logic [DW-1:0] VEC_RST = 8'h0F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] evt_i,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          iack_n,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_rdata_oe,
  output logic          dack_n,
  output logic          irq_n
);
  logic [DW-1:0] status, mask, vector;
  logic          wr_en;

  irqv_status #(.N(DW)) u_status (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .status_o(status));

  irqv_regs #(.DW(DW), .AW(AW), .VEC_RST(VEC_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(cpu_addr),
    .wdata(cpu_wdata), .mask_o(mask), .vector_o(vector));

  irqv_req #(.N(DW)) u_req (
    .clk(clk), .rst_n(rst_n), .status(status), .mask(mask), .irq_n(irq_n));

  irqv_bus #(.DW(DW), .AW(AW)) u_bus (
    .clk(clk), .rst_n(rst_n), .rd(cpu_rd), .wr(cpu_wr), .addr(cpu_addr),
    .iack_n(iack_n), .irq_n(irq_n), .status(status), .mask(mask),
    .vector(vector), .wr_accept(wr_en), .rdata(cpu_rdata),
    .rdata_oe(cpu_rdata_oe), .dack_n(dack_n));

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0 && $past(mask) == '0) |-> irq_n); // R5
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & mask) == '0) |=> irq_n); // R4
endmodule

// File: tb/tb_irqv_top.sv
module tb_irqv_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_i = '0;
  logic       cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [1:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic       iack_n = 1'b1;
  logic [7:0] cpu_rdata;
  logic       cpu_rdata_oe, dack_n, irq_n;

  int vecs = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irqv_top dut (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cpu_rd = 1'b1; cpu_addr = a;
    @(negedge clk); cpu_rd = 1'b0;
    chk("R8 read dack_n", {7'b0, dack_n}, 8'h00);
    chk("R8 read oe", {7'b0, cpu_rdata_oe}, 8'h01);
    d = cpu_rdata;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_wr = 1'b0;
    chk("R8 write dack_n", {7'b0, dack_n}, 8'h00);
    chk("R8 write oe", {7'b0, cpu_rdata_oe}, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
    chk("R1 dack_n", {7'b0, dack_n}, 8'h01);
    chk("R1 oe", {7'b0, cpu_rdata_oe}, 8'h00);
    rd_reg(2'd1, d); chk("R1 mask", d, 8'h00);
    rd_reg(2'd2, d); chk("R1 vector", d, 8'h0F);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr_reg(2'd1, 8'hA5); rd_reg(2'd1, d); chk("R3 mask rw", d, 8'hA5);
    wr_reg(2'd2, 8'h5C); rd_reg(2'd2, d); chk("R3 vector rw", d, 8'h5C);
    wr_reg(2'd3, 8'hFF); rd_reg(2'd3, d); chk("R3 addr3 reads 0", d, 8'h00);
    wr_reg(2'd0, 8'hFF); rd_reg(2'd0, d); chk("R3 status write ignored", d, 8'h00);
    rd_reg(2'd1, d); chk("R3 mask untouched", d, 8'hA5);
    rd_reg(2'd2, d); chk("R3 vector untouched", d, 8'h5C);
    wr_reg(2'd1, 8'h00);
  endtask

  task automatic t_status();
    logic [7:0] d;
    @(negedge clk); evt_i = 8'h3C;
    rd_reg(2'd0, d); chk("R2 status masked events", d, 8'h3C);
    chk("R5 masked no irq", {7'b0, irq_n}, 8'h01);
    rd_reg(2'd0, d); chk("R10 status kept after read", d, 8'h3C);
    @(negedge clk); evt_i = 8'h00;
    rd_reg(2'd0, d); chk("R10 status clears with source", d, 8'h00);
  endtask

  task automatic t_irq();
    wr_reg(2'd1, 8'h10);
    @(negedge clk); evt_i = 8'h01;
    @(negedge clk); @(negedge clk);
    chk("R5 unmasked bit only", {7'b0, irq_n}, 8'h01);
    evt_i = 8'h10;
    @(negedge clk);
    chk("R4 not yet after one clock", {7'b0, irq_n}, 8'h01);
    @(negedge clk);
    chk("R4 asserted after two clocks", {7'b0, irq_n}, 8'h00);
    evt_i = 8'h00;
    @(negedge clk);
    chk("R4 still low while status holds", {7'b0, irq_n}, 8'h00);
    @(negedge clk);
    chk("R4 released", {7'b0, irq_n}, 8'h01);
  endtask

  task automatic t_iack();
    @(negedge clk); evt_i = 8'h10;
    @(negedge clk); @(negedge clk);
    chk("R6 pending", {7'b0, irq_n}, 8'h00);
    iack_n = 1'b0;
    @(negedge clk); iack_n = 1'b1;
    chk("R6 vector", cpu_rdata, 8'h5C);
    chk("R6 oe", {7'b0, cpu_rdata_oe}, 8'h01);
    chk("R6 dack_n", {7'b0, dack_n}, 8'h00);
    iack_n = 1'b0; cpu_rd = 1'b1; cpu_addr = 2'd1;
    @(negedge clk); iack_n = 1'b1; cpu_rd = 1'b0;
    chk("R9 vector wins over read", cpu_rdata, 8'h5C);
    evt_i = 8'h00;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_iack_idle();
    logic [7:0] d;
    chk("R7 idle line", {7'b0, irq_n}, 8'h01);
    @(negedge clk); iack_n = 1'b0;
    @(negedge clk);
    chk("R7 dack_n", {7'b0, dack_n}, 8'h01);
    chk("R7 oe", {7'b0, cpu_rdata_oe}, 8'h00);
    iack_n = 1'b1;
    @(negedge clk); evt_i = 8'h10;
    @(negedge clk); @(negedge clk);
    iack_n = 1'b0; cpu_wr = 1'b1; cpu_addr = 2'd2; cpu_wdata = 8'h77;
    @(negedge clk); iack_n = 1'b1; cpu_wr = 1'b0; evt_i = 8'h00;
    @(negedge clk); @(negedge clk);
    rd_reg(2'd2, d); chk("R9 write dropped under iack", d, 8'h5C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_status();
    t_irq();
    t_iack();
    t_iack_idle();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1;
      vecs++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule